// File: doc/BRIEF.md
# Lockable Watchdog Interval Timer

This block is a watchdog counter that advances on a dedicated tick-enable input. Once started it counts ticks and, when it has seen a full programmed period, requests a watchdog reset for one clock cycle and starts over from zero. The period is a power of two of watchdog ticks, chosen by a 3-bit interval-select value `n`: the period is 2^(`BASE_EXP`+n) ticks. With the default `BASE_EXP` of 13 this spans 2^13 to 2^20 ticks.

Software reaches the block through a one-cycle write port and a combinational read port. There are three registers: a command register, the interval-select register and a mode register that holds a run bit and a lock bit. The select value changes only through a two-step sequence. The first write goes to the command register, and its data is ignored. The second write, in the very next cycle, goes to the select register. While the timer runs, this sequence succeeds only once per reset. The success sets the lock bit, which freezes the interval.

Two synchronous, active-low reset inputs are modelled. The watchdog reset stops and clears everything. The general system reset restores the select register to its longest setting and clears the lock bit, but it leaves a running watchdog running. A controller state machine holds the run state, the lock state and the pending command as one state value. Its states are:

- STOP
- STOP_ARM (stopped, command just written)
- RUN
- RUN_ARM (running, command just written)
- LOCK (running, interval frozen)

Its transitions are:

- STOP to STOP_ARM on a command write.
- STOP or STOP_ARM to RUN on a mode write with the run bit set.
- STOP_ARM stays in STOP_ARM on another command write. Any other cycle returns it to STOP, and a select write in that cycle is accepted.
- RUN to RUN_ARM on a command write.
- RUN_ARM to LOCK on a select write, which is accepted. RUN_ARM stays in RUN_ARM on another command write. Any other cycle returns it to RUN.
- LOCK stays in LOCK.
- The system reset sends every running state to RUN and every stopped state to STOP.
- The watchdog reset sends every state to STOP.

Top module: `wdt_interval_timer`

## Requirements
- R1: Once started, the block requests a reset after exactly 2^(`BASE_EXP`+n) cycles in which `tick_en` was high, where n is the select value. Cycles with `tick_en` low do not advance the count.
- R2: Either reset, while low at a clock edge, sets the select value to 7, clears the tick count and keeps `wdt_reset_req` low.
- R3: The watchdog reset clears both the run bit and the lock bit. After it, no reset request appears however many ticks arrive, until the timer is started again.
- R4: The system reset leaves the run bit unchanged, clears the lock bit and cancels a pending command. A running timer then counts a full period from zero.
- R5: A write to the select register (address 1) is accepted only if the write in the immediately preceding cycle went to the command register (address 0), whatever its data. An idle cycle or a write to any other address in between causes the select write to be ignored. Repeated command writes keep the sequence open.
- R6: An accepted select write clears the tick count, so the next request comes a full new period later. If a tick arrives in the same cycle as an accepted select write, the select write wins: the count clears and no request is raised, even if that tick would have completed a period.
- R7: An accepted select write while running sets the lock bit, and later select writes are ignored until a reset. An accepted select write while stopped leaves the lock bit at 0.
- R8: A mode-register write (address 2) with data bit 0 set starts the timer. A mode write with bit 0 clear does not stop a running timer.
- R9: A reset request lasts exactly one cycle, and the count wraps to zero, so requests repeat every period.
- R10: Reads return the following values:
  - Address 1: the select value in bits [2:0], other bits zero.
  - Address 2: the run bit in bit 0 and the lock bit in bit 1, other bits zero.
  - Address 0 and address 3: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | General system reset, synchronous, active low |
| wdt_rst_n | input | 1 | Watchdog-caused reset, synchronous, active low |
| tick_en | input | 1 | Watchdog clock enable; one tick per high cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 select, 2 mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wdt_reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The case that needs the most care is a running counter that sits at its last tick value when an accepted select write arrives. The command write is made with `tick_en` low. In the following cycle the select write is presented together with a tick that would complete the period. The bench then checks that no request appears in the next cycle, that the new select value reads back, and that the next request comes exactly one full new period of ticks later. Overflow timing is also swept over all eight select values, with dense and sparse tick patterns, in a small configuration with `BASE_EXP` = 2.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        ST_STOP,
        ST_STOP_ARM,
        ST_RUN,
        ST_RUN_ARM,
        ST_LOCK
    } wdt_state_e;

    localparam int ADDR_W        = 2;
    localparam int DATA_W        = 8;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_SEL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE = 2'd2;
    localparam int MODE_RUN_BIT  = 0;
    localparam int MODE_LOCK_BIT = 1;
endpackage

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              wdt_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_run,
    output logic              sel_load,
    output logic              run_o,
    output logic              locked_o
);
    wdt_state_e state_q, state_nx;
    logic wr_cmd, wr_sel, wr_mode, running;

    assign wr_cmd  = wr_en && (wr_addr == ADR_CMD);
    assign wr_sel  = wr_en && (wr_addr == ADR_SEL);
    assign wr_mode = wr_en && (wr_addr == ADR_MODE);
    assign running = (state_q == ST_RUN) || (state_q == ST_RUN_ARM) || (state_q == ST_LOCK);

    // state register: watchdog reset stops, system reset keeps run state
    always_ff @(posedge clk) begin
        if (!wdt_rst_n)
            state_q <= ST_STOP;
        else if (!sys_rst_n)
            state_q <= running ? ST_RUN : ST_STOP;
        else
            state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (wr_cmd)                 state_nx = ST_STOP_ARM;
                else if (wr_mode && wr_run) state_nx = ST_RUN;
            end
            ST_STOP_ARM: begin
                if (wr_cmd)                 state_nx = ST_STOP_ARM;
                else if (wr_mode && wr_run) state_nx = ST_RUN;
                else                        state_nx = ST_STOP;
            end
            ST_RUN: begin
                if (wr_cmd)                 state_nx = ST_RUN_ARM;
            end
            ST_RUN_ARM: begin
                if (wr_sel)                 state_nx = ST_LOCK;
                else if (wr_cmd)            state_nx = ST_RUN_ARM;
                else                        state_nx = ST_RUN;
            end
            ST_LOCK:                        state_nx = ST_LOCK;
            default:                        state_nx = ST_STOP;
        endcase
    end

    // outputs
    always_comb begin
        sel_load = 1'b0;
        run_o    = 1'b0;
        locked_o = 1'b0;
        unique case (state_q)
            ST_STOP:     ;
            ST_STOP_ARM: sel_load = wr_sel;
            ST_RUN:      run_o = 1'b1;
            ST_RUN_ARM: begin
                run_o    = 1'b1;
                sel_load = wr_sel;
            end
            ST_LOCK: begin
                run_o    = 1'b1;
                locked_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: software cannot stop a running timer
    a_r8_run_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        run_o |=> run_o);
    // R7: lock persists until a reset
    a_r7_lock_holds: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        locked_o |=> (locked_o && !sel_load));
endmodule

// File: rtl/wdt_interval_reg.sv
module wdt_interval_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             wdt_rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] din,
    output logic [SEL_W-1:0] sel
);
    always_ff @(posedge clk) begin
        if (!sys_rst_n || !wdt_rst_n)
            sel <= '1;
        else if (load)
            sel <= din;
    end

    // R5: the value moves only on an accepted load
    a_r5_sel_needs_load: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        !load |=> $stable(sel));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int BASE_EXP = 13,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             wdt_rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             req
);
    localparam int SH_W = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [SH_W-1:0]  shamt;

    // last count value before wrap: 2^(BASE_EXP+sel) - 1
    assign shamt = SH_W'(BASE_EXP) + SH_W'(sel);
    assign limit = (CNT_W'(1) << shamt) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!sys_rst_n || !wdt_rst_n) begin
            cnt_q <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (run && tick_en) begin
                if (cnt_q == limit) begin
                    cnt_q <= '0;
                    req   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R1: no advance without a tick
    a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        (!(run && tick_en) && !clr) |=> $stable(cnt_q));
    // R6: clearing write wins over overflow
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        clr |=> (cnt_q == '0 && !req));
    // R9: request is a single-cycle pulse
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n || !wdt_rst_n)
        req |=> !req);
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int SEL_W    = 3
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              wdt_rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_reset_req
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    logic             sel_load, run, locked;
    logic [SEL_W-1:0] sel;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DATA_W-1:SEL_W];

    wdt_ctrl_fsm u_ctrl (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .wdt_rst_n (wdt_rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_run    (wr_data[MODE_RUN_BIT]),
        .sel_load  (sel_load),
        .run_o     (run),
        .locked_o  (locked)
    );

    wdt_interval_reg #(.SEL_W(SEL_W)) u_sel (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .wdt_rst_n (wdt_rst_n),
        .load      (sel_load),
        .din       (wr_data[SEL_W-1:0]),
        .sel       (sel)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .wdt_rst_n (wdt_rst_n),
        .run       (run),
        .tick_en   (tick_en),
        .clr       (sel_load),
        .sel       (sel),
        .req       (wdt_reset_req)
    );

    // R10: read map
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_SEL:  rd_data[SEL_W-1:0] = sel;
            ADR_MODE: begin
                rd_data[MODE_RUN_BIT]  = run;
                rd_data[MODE_LOCK_BIT] = locked;
            end
            default: ;
        endcase
    end
endmodule

// File: tb/wdt_interval_timer_tb.sv
`timescale 1ns/1ps
module wdt_interval_timer_tb;
    localparam int BE = 2;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b1, wdt_rst_n = 1'b1;
    logic       tick_en = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       wdt_reset_req;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdt_interval_timer #(.BASE_EXP(BE), .SEL_W(3)) u_dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .wdt_rst_n(wdt_rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdt_reset_req(wdt_reset_req));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic tk);
        tick_en = tk;
        @(posedge clk); #1;
        tick_en = 1'b0;
    endtask

    task automatic wr_tk(input logic [1:0] a, input logic [7:0] d, input logic tk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = tk;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_tk(a, d, 1'b0);
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        rd_addr = a; #1; d = int'(rd_data);
    endtask

    task automatic hard_reset();
        wdt_rst_n = 1'b0; sys_rst_n = 1'b0;
        step(0); step(0);
        wdt_rst_n = 1'b1; sys_rst_n = 1'b1;
    endtask

    task automatic sys_reset();
        sys_rst_n = 1'b0; step(1); sys_rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1);
    endtask

    // expected period computed from the select value
    task automatic run_period(input int n, input int gap, input string tag);
        int period, seen, early;
        period = 1 << (BE + n); seen = 0; early = 0;
        for (int k = 1; k <= period; k++) begin
            for (int g = 0; g < gap; g++) begin
                step(0);
                if (wdt_reset_req) early++;
            end
            step(1);
            if (wdt_reset_req && seen == 0) seen = k;
        end
        chk({tag, " period"}, seen, period);
        chk({tag, " no request in idle cycles"}, early, 0);
        step(0);
        chk("R9 request lasts one cycle", int'(wdt_reset_req), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, cnt;
        hard_reset();
        rd(2'd1, v); chk("R2 select after reset", v, 7);
        rd(2'd2, v); chk("R10 mode after reset", v, 0);
        rd(2'd0, v); chk("R10 command reads zero", v, 0);
        rd(2'd3, v); chk("R10 unused address reads zero", v, 0);
        chk("R2 request low after reset", int'(wdt_reset_req), 0);

        // R1/R9 sweep of every select value with dense and sparse ticks
        for (int n = 0; n < 8; n++) begin
            hard_reset();
            wr(2'd0, 8'hA5 ^ 8'(n));
            wr(2'd1, 8'(n));
            rd(2'd1, v); chk("R5 select accepted after command", v, n);
            wr(2'd2, 8'h01);
            rd(2'd2, v); chk("R7 stopped write leaves lock clear", v, 1);
            run_period(n, n % 3, "R1");
            run_period(n, 0, "R9 wrap");
        end

        // R5 rejected sequences
        hard_reset();
        wr(2'd1, 8'd2);
        rd(2'd1, v); chk("R5 select without command", v, 7);
        wr(2'd0, 8'd0); step(0); wr(2'd1, 8'd2);
        rd(2'd1, v); chk("R5 idle cycle breaks sequence", v, 7);
        wr(2'd0, 8'd0); wr(2'd2, 8'd0); wr(2'd1, 8'd2);
        rd(2'd1, v); chk("R5 mode write breaks sequence", v, 7);
        wr(2'd0, 8'd0); wr(2'd0, 8'hFF); wr(2'd1, 8'd2);
        rd(2'd1, v); chk("R5 repeated command keeps sequence", v, 2);

        // R7 lock while running, R6 counter cleared
        hard_reset();
        wr(2'd0, 8'd0); wr(2'd1, 8'd1);
        wr(2'd2, 8'h01);
        ticks(5);
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        rd(2'd1, v); chk("R7 running select accepted", v, 0);
        rd(2'd2, v); chk("R7 lock set", v, 3);
        run_period(0, 0, "R6 count restarts from zero");
        wr(2'd0, 8'd0); wr(2'd1, 8'd5);
        rd(2'd1, v); chk("R7 locked select ignored", v, 0);
        run_period(0, 0, "R7 period unchanged");
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R8 run cannot be cleared", v, 3);

        // R4 system reset keeps the timer running
        ticks(3);
        sys_reset();
        rd(2'd2, v); chk("R4 run kept, lock cleared", v, 1);
        rd(2'd1, v); chk("R2 system reset select", v, 7);
        run_period(7, 0, "R4 full period after system reset");
        wr(2'd0, 8'd0); wr(2'd1, 8'd3);
        rd(2'd1, v); chk("R4 one write allowed again", v, 3);
        rd(2'd2, v); chk("R4 lock set again", v, 3);

        // R4 pending command cancelled by system reset
        hard_reset();
        wr(2'd0, 8'd0);
        sys_rst_n = 1'b0; step(0); sys_rst_n = 1'b1;
        wr(2'd1, 8'd4);
        rd(2'd1, v); chk("R4 pending command cancelled", v, 7);
        rd(2'd2, v); chk("R4 stopped timer stays stopped", v, 0);

        // R3 watchdog reset stops the timer
        hard_reset();
        wr(2'd2, 8'h01);
        ticks(2);
        wdt_rst_n = 1'b0; step(1); wdt_rst_n = 1'b1;
        rd(2'd2, v); chk("R3 run and lock cleared", v, 0);
        rd(2'd1, v); chk("R2 watchdog reset select", v, 7);
        cnt = 0;
        for (int i = 0; i < 600; i++) begin
            step(1);
            if (wdt_reset_req) cnt++;
        end
        chk("R3 no request while stopped", cnt, 0);

        // R6 collision: accepted select write and completing tick in one cycle
        hard_reset();
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        wr(2'd2, 8'h01);
        ticks(3);
        wr(2'd0, 8'd0);
        wr_tk(2'd1, 8'd2, 1'b1);
        chk("R6 select write beats overflow", int'(wdt_reset_req), 0);
        rd(2'd1, v); chk("R6 new select value", v, 2);
        run_period(2, 0, "R6 new period from zero");

        finish_run();
    end
endmodule